// File: doc/BRIEF.md
# Authenticated-Cipher Segment Input Parser

This block sits between two input word streams and an authenticated-cipher core. One stream carries secret material and the other carries public material. Each stream opens with an instruction word and then carries a run of segments. Each segment is a header word followed by its payload words. The parser handles the secret stream first. When that stream's final segment is done, it moves to the public stream. Payload words go to the core one at a time, each tagged with its segment type, its input identifier, the number of valid bytes it holds and a flag on the final word of the segment.

Segment lengths are counted in bytes. The parser reads ceil(length / bytes-per-word) payload words, and a zero-length segment has no payload at all. A segment type that is illegal, or legal but on the wrong stream, raises a one-cycle error pulse with an 8-bit code. The parser then drops the segment and waits for a fresh instruction word on the secret stream. When the public stream's final segment has been consumed, a one-cycle done pulse marks the end of the transaction.

Top module: `seg_input_parser`

## Requirements
- R1: A word moves only in a cycle where the active stream's ready is high and the parser drives that stream's read strobe. The inactive stream's read strobe stays low, so the two strobes are never high together.
- R2: Header fields by bit position: segment type in [3:0], last-segment flag in bit 7, input identifier in [15:8], byte length in [W-1:16]. Bits [6:4] are ignored.
- R3: A segment of length L yields exactly ceil(L / (W/8)) payload words. Each word appears on out_data with out_valid high one cycle after it is read, carrying the header's type and identifier.
- R4: Every payload word except the last of its segment reports W/8 valid bytes on out_bytes with out_end low. The last word reports L - (n-1)*(W/8) bytes, which is between 1 and W/8, with out_end high.
- R5: A zero-length segment consumes no payload words. The next word read on that stream is treated as a header.
- R6: When a secret-stream segment with the last flag set ends, the parser switches to reading an instruction word on the public stream. When a public-stream segment with the last flag set ends, done pulses high for one cycle: together with that segment's last out_valid, or one cycle after its header if it has no payload.
- R7: A segment type of 0 or of 7 to 15 pulses err for one cycle with err_code 0x01, one cycle after the header is read.
- R8: A key segment (type 6) on the public stream pulses err with err_code 0x02.
- R9: A segment of any type other than key on the secret stream pulses err with err_code 0x03.
- R10: After an error, no payload of the offending segment is forwarded. The parser returns to waiting for an instruction word on the secret stream.
- R11: While rst is high, and after it falls, out_valid, done and err are low. The parser waits for an instruction word on the secret stream and does not read the public stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdi_data | input | W | Public stream word |
| pdi_ready | input | 1 | Public stream has a word |
| pdi_read | output | 1 | Public stream read strobe |
| sdi_data | input | W | Secret stream word |
| sdi_ready | input | 1 | Secret stream has a word |
| sdi_read | output | 1 | Secret stream read strobe |
| out_valid | output | 1 | Payload word valid to core |
| out_data | output | W | Payload word |
| out_type | output | 4 | Segment type of the word |
| out_id | output | 8 | Input identifier of the segment |
| out_bytes | output | $clog2(W/8+1) | Valid bytes in the word |
| out_end | output | 1 | Last word of the segment |
| done | output | 1 | Public stream finished |
| err | output | 1 | Malformed input pulse |
| err_code | output | 8 | Error code, valid with err |

## Verification
The bench targets five corner cases:
- A zero-length segment in mid stream: a parser that reads a payload word for it would swallow the next header and tag every later word wrongly.
- A segment length that is not a multiple of the word size: an off-by-one count would report a wrong byte total on the final word or read one word too many.
- A key segment on the public side and a non-key segment on the secret side: each must raise its own code, and a design that mixed them up would report the wrong cause.
- Recovery after an error: a design that kept the stale stream or segment would either stall or forward payload from the rejected segment.
- Intermittent ready: a parser that ignored ready would duplicate or skip words.

// File: rtl/seg_parser_pkg.sv
package seg_parser_pkg;
  typedef enum logic [3:0] {
    ST_RSV = 4'd0,
    ST_IV  = 4'd1,
    ST_AD  = 4'd2,
    ST_MSG = 4'd3,
    ST_CT  = 4'd4,
    ST_TAG = 4'd5,
    ST_KEY = 4'd6
  } seg_type_e;

  typedef enum logic [1:0] {
    PS_INSTR = 2'd0,
    PS_HDR   = 2'd1,
    PS_DATA  = 2'd2
  } parse_state_e;

  localparam logic [7:0] EC_NONE     = 8'h00;
  localparam logic [7:0] EC_RESERVED = 8'h01;
  localparam logic [7:0] EC_KEY_PUB  = 8'h02;
  localparam logic [7:0] EC_SEC_TYPE = 8'h03;
endpackage

// File: rtl/seg_hdr_decode.sv
module seg_hdr_decode
  import seg_parser_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]  hdr,
  input  logic          from_secret,
  output logic [3:0]    typ,
  output logic          last,
  output logic [7:0]    id,
  output logic [W-17:0] len,
  output logic          bad,
  output logic [7:0]    code
);
  logic is_rsv;

  assign typ    = hdr[3:0];
  assign last   = hdr[7];
  assign id     = hdr[15:8];
  assign len    = hdr[W-1:16];
  assign is_rsv = (typ == ST_RSV) || (typ > ST_KEY);

  always_comb begin
    bad  = 1'b1;
    code = EC_NONE;
    if (is_rsv)                                code = EC_RESERVED;
    else if (from_secret && typ != ST_KEY)     code = EC_SEC_TYPE;
    else if (!from_secret && typ == ST_KEY)    code = EC_KEY_PUB;
    else                                       bad  = 1'b0;
  end
endmodule

// File: rtl/seg_byte_tracker.sv
module seg_byte_tracker #(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [W-17:0]              len,
  input  logic                       step,
  output logic                       final_word,
  output logic [$clog2(W/8+1)-1:0]   chunk
);
  localparam int BPW   = W / 8;
  localparam int LEN_W = W - 16;
  localparam int CNT_W = $clog2(BPW + 1);

  logic [LEN_W-1:0] rem;

  assign final_word = (rem <= LEN_W'(BPW));
  assign chunk      = final_word ? rem[CNT_W-1:0] : CNT_W'(BPW);

  always_ff @(posedge clk) begin
    if (rst)       rem <= '0;
    else if (load) rem <= len;
    else if (step) rem <= final_word ? '0 : rem - LEN_W'(BPW);
  end
endmodule

// File: rtl/seg_input_parser.sv
module seg_input_parser
  import seg_parser_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [W-1:0]               pdi_data,
  input  logic                       pdi_ready,
  output logic                       pdi_read,
  input  logic [W-1:0]               sdi_data,
  input  logic                       sdi_ready,
  output logic                       sdi_read,
  output logic                       out_valid,
  output logic [W-1:0]               out_data,
  output logic [3:0]                 out_type,
  output logic [7:0]                 out_id,
  output logic [$clog2(W/8+1)-1:0]   out_bytes,
  output logic                       out_end,
  output logic                       done,
  output logic                       err,
  output logic [7:0]                 err_code
);
  localparam int BPW   = W / 8;
  localparam int LEN_W = W - 16;
  localparam int CNT_W = $clog2(BPW + 1);

  parse_state_e     st;
  logic             src_sec;
  logic [3:0]       cur_type;
  logic [7:0]       cur_id;
  logic             cur_last;

  logic [W-1:0]     act_word;
  logic             take, hdr_take, data_take;
  logic [3:0]       d_type;
  logic             d_last, d_bad;
  logic [7:0]       d_id, d_code;
  logic [LEN_W-1:0] d_len;
  logic             fin_word;
  logic [CNT_W-1:0] chunk;
  logic             seg_over, stream_over;

  assign sdi_read  = src_sec & sdi_ready;
  assign pdi_read  = ~src_sec & pdi_ready;
  assign take      = sdi_read | pdi_read;
  assign act_word  = src_sec ? sdi_data : pdi_data;
  assign hdr_take  = take && (st == PS_HDR);
  assign data_take = take && (st == PS_DATA);

  seg_hdr_decode #(.W(W)) dec_i (
    .hdr(act_word), .from_secret(src_sec), .typ(d_type), .last(d_last),
    .id(d_id), .len(d_len), .bad(d_bad), .code(d_code)
  );

  seg_byte_tracker #(.W(W)) trk_i (
    .clk(clk), .rst(rst), .load(hdr_take && !d_bad), .len(d_len),
    .step(data_take), .final_word(fin_word), .chunk(chunk)
  );

  assign seg_over    = (hdr_take && !d_bad && d_len == '0) || (data_take && fin_word);
  assign stream_over = hdr_take ? d_last : cur_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PS_INSTR;
      src_sec   <= 1'b1;
      cur_type  <= '0;
      cur_id    <= '0;
      cur_last  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_type  <= '0;
      out_id    <= '0;
      out_bytes <= '0;
      out_end   <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= EC_NONE;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      case (st)
        PS_INSTR: if (take) st <= PS_HDR;
        PS_HDR: if (take) begin
          if (d_bad) begin
            err      <= 1'b1;
            err_code <= d_code;
            st       <= PS_INSTR;
            src_sec  <= 1'b1;
          end else begin
            cur_type <= d_type;
            cur_id   <= d_id;
            cur_last <= d_last;
            st       <= (d_len == '0) ? PS_HDR : PS_DATA;
          end
        end
        PS_DATA: if (take) begin
          out_valid <= 1'b1;
          out_data  <= act_word;
          out_type  <= cur_type;
          out_id    <= cur_id;
          out_bytes <= chunk;
          out_end   <= fin_word;
        end
        default: st <= PS_INSTR;
      endcase
      if (seg_over) begin
        if (stream_over) begin
          st      <= PS_INSTR;
          src_sec <= ~src_sec;
          done    <= ~src_sec;
        end else begin
          st <= PS_HDR;
        end
      end
    end
  end

  // R1
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pdi_read, sdi_read}));
  // R4
  mid_word_full_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_end) |-> (out_bytes == CNT_W'(BPW)));
  // R4
  end_word_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_end) |-> (out_bytes != '0 && out_bytes <= CNT_W'(BPW)));
  // R9
  key_from_secret_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_type == ST_KEY) |-> $past(sdi_read));
  // R10
  err_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !out_valid);
  // R10
  err_restart_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !pdi_read);
  // R6
  done_not_err_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !err);
endmodule

// File: tb/seg_input_parser_tb.sv
module seg_input_parser_tb_top;
  localparam int W = 32;
  localparam int CW = 3;

  function automatic logic [W-1:0] hdr(input int t, input int ls, input int id, input int len);
    return {len[15:0], id[7:0], ls[0], 3'b000, t[3:0]};
  endfunction
  function automatic logic [49:0] ve(input int t, input int id, input int b, input int e, input logic [31:0] d);
    return {2'd2, id[7:0], t[3:0], b[2:0], e[0], d};
  endfunction

  localparam int NV = 26;
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 16'h0, 32'hA000_0001},
    {2'd0, 16'h0, hdr(6, 1, 8'h11, 16)},
    {2'd0, 16'h0, 32'h1111_0000}, {2'd0, 16'h0, 32'h1111_0001},
    {2'd0, 16'h0, 32'h1111_0002}, {2'd0, 16'h0, 32'h1111_0003},
    {2'd1, 16'h0, 32'hB000_0002},
    {2'd1, 16'h0, hdr(1, 0, 8'h22, 12)},
    {2'd1, 16'h0, 32'h2222_0000}, {2'd1, 16'h0, 32'h2222_0001}, {2'd1, 16'h0, 32'h2222_0002},
    {2'd1, 16'h0, hdr(2, 0, 8'h23, 0)},
    {2'd1, 16'h0, hdr(3, 1, 8'h24, 6)},
    {2'd1, 16'h0, 32'h3333_0000}, {2'd1, 16'h0, 32'h3333_0001},
    ve(6, 8'h11, 4, 0, 32'h1111_0000), ve(6, 8'h11, 4, 0, 32'h1111_0001),
    ve(6, 8'h11, 4, 0, 32'h1111_0002), ve(6, 8'h11, 4, 1, 32'h1111_0003),
    ve(1, 8'h22, 4, 0, 32'h2222_0000), ve(1, 8'h22, 4, 0, 32'h2222_0001),
    ve(1, 8'h22, 4, 1, 32'h2222_0002),
    ve(3, 8'h24, 4, 0, 32'h3333_0000), ve(3, 8'h24, 2, 1, 32'h3333_0001),
    {2'd3, 48'h0}, {2'd3, 48'h0}
  };

  logic clk = 0, rst = 1;
  logic [W-1:0] pdi_data, sdi_data, out_data;
  logic pdi_ready, pdi_read, sdi_ready, sdi_read;
  logic out_valid, out_end, done, err;
  logic [3:0] out_type;
  logic [7:0] out_id, err_code, last_code;
  logic [CW-1:0] out_bytes;

  logic [W-1:0] smem [16];
  logic [W-1:0] pmem [16];
  logic [47:0]  emem [16];
  int sn, pn, en, si, pi, ei, dn, ern, errors, checks, cyc;
  logic gate, stall_en;

  always #2.5 clk = ~clk;

  assign sdi_data  = smem[si[3:0]];
  assign pdi_data  = pmem[pi[3:0]];
  assign sdi_ready = (si < sn) && gate;
  assign pdi_ready = (pi < pn) && gate;

  seg_input_parser #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .pdi_data(pdi_data), .pdi_ready(pdi_ready), .pdi_read(pdi_read),
    .sdi_data(sdi_data), .sdi_ready(sdi_ready), .sdi_read(sdi_read),
    .out_valid(out_valid), .out_data(out_data), .out_type(out_type), .out_id(out_id),
    .out_bytes(out_bytes), .out_end(out_end), .done(done), .err(err), .err_code(err_code)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sdi_read) si <= si + 1;
    if (pdi_read) pi <= pi + 1;
  end

  always @(negedge clk) begin
    gate <= stall_en ? ~gate : 1'b1;
    if (!rst) begin
      if (out_valid) begin
        if (ei < en)
          chk({out_id, out_type, out_bytes, out_end, out_data} == emem[ei[3:0]],
              "R3/R4 payload word", 64'({out_id, out_type, out_bytes, out_end, out_data}), 64'(emem[ei[3:0]]));
        else chk(1'b0, "R3 extra payload word", 64'(out_data), 64'(0));
        ei++;
      end
      if (done) dn++;
      if (err) begin ern++; last_code = err_code; end
    end
  end

  task automatic restart(input logic stall);
    @(negedge clk);
    rst = 1; stall_en = stall;
    sn = 0; pn = 0; en = 0; si = 0; pi = 0; ei = 0; dn = 0; ern = 0; last_code = 8'h00;
    @(negedge clk);
    chk(!out_valid && !done && !err, "R11 outputs in reset", 64'({out_valid, done, err}), 64'(0));
    rst = 0;
  endtask

  task automatic ps(input logic [W-1:0] w); smem[sn[3:0]] = w; sn++; endtask
  task automatic pp(input logic [W-1:0] w); pmem[pn[3:0]] = w; pn++; endtask
  task automatic pe(input logic [47:0] e); emem[en[3:0]] = e; en++; endtask

  task automatic finish_test(input string tag, input int exp_done, input int exp_err, input logic [7:0] exp_code);
    repeat (80) @(negedge clk);
    chk(ei == en, {tag, " word count"}, 64'(ei), 64'(en));
    chk(si == sn && pi == pn, {tag, " words consumed"}, 64'({si[15:0], pi[15:0]}), 64'({sn[15:0], pn[15:0]}));
    chk(dn == exp_done, {tag, " done pulses"}, 64'(dn), 64'(exp_done));
    chk(ern == exp_err, {tag, " err pulses"}, 64'(ern), 64'(exp_err));
    if (exp_err > 0) chk(last_code == exp_code, {tag, " err code"}, 64'(last_code), 64'(exp_code));
  endtask

  initial begin
    errors = 0; checks = 0; cyc = 0; gate = 1; stall_en = 0;
    sn = 0; pn = 0; en = 0; si = 0; pi = 0; ei = 0;
    repeat (3) @(negedge clk);

    // R11: public words pending, secret stream empty: nothing must be read
    restart(1'b0);
    pp(32'hB000_0002); pp(hdr(3, 1, 1, 4));
    repeat (6) @(negedge clk);
    chk(pi == 0, "R11 public stream untouched before secret", 64'(pi), 64'(0));
    chk(!out_valid && !done, "R11 idle outputs", 64'({out_valid, done}), 64'(0));

    // R1 R2 R3 R4 R5 R6: vector table, once stalled and once back to back
    for (int pass = 0; pass < 2; pass++) begin
      restart(pass == 0);
      for (int k = 0; k < NV; k++) begin
        case (VEC[k][49:48])
          2'd0: ps(VEC[k][31:0]);
          2'd1: pp(VEC[k][31:0]);
          2'd2: pe(VEC[k][47:0]);
          default: ;
        endcase
      end
      finish_test(pass == 0 ? "R1 R5 R6 stalled" : "R3 R6 back-to-back", 1, 0, 8'h00);
    end

    // R6: zero-length final public segment: done one cycle after header
    restart(1'b0);
    ps(32'h1); ps(hdr(6, 1, 5, 3)); ps(32'hCAFE_0000);
    pe({8'd5, 4'd6, 3'd3, 1'b1, 32'hCAFE_0000});
    pp(32'h2); pp(hdr(5, 1, 6, 0));
    finish_test("R6 zero-length last", 1, 0, 8'h00);

    // R9 R10: message on secret stream, then valid transaction recovers
    restart(1'b0);
    ps(32'h1); ps(hdr(3, 1, 7, 4));
    ps(32'h1); ps(hdr(6, 1, 8, 4)); ps(32'h4444_0000);
    pe({8'd8, 4'd6, 3'd4, 1'b1, 32'h4444_0000});
    pp(32'h2); pp(hdr(3, 1, 9, 3)); pp(32'h5555_0000);
    pe({8'd9, 4'd3, 3'd3, 1'b1, 32'h5555_0000});
    finish_test("R9 R10 recovery", 1, 1, 8'h03);

    // R8 R10: key on public stream; its payload must stay unread
    restart(1'b0);
    ps(32'h1); ps(hdr(6, 1, 1, 4)); ps(32'h6666_0000);
    pe({8'd1, 4'd6, 3'd4, 1'b1, 32'h6666_0000});
    pp(32'h2); pp(hdr(6, 1, 2, 4));
    finish_test("R8 key on public", 0, 1, 8'h02);

    // R7: reserved codes 0 and 9 on the secret stream
    restart(1'b0);
    ps(32'h1); ps(hdr(0, 1, 1, 4));
    ps(32'h1); ps(hdr(9, 1, 1, 4));
    finish_test("R7 reserved types", 0, 2, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule